// File: doc/BRIEF.md
# Host Interface Interrupt Register Block

This block is a small memory-mapped register file on a simple word-wide bus slave port. It keeps two outbound descriptor words, a control word, an interrupt status word and a software interrupt word. It drives a single level-sensitive interrupt line. Software reads each register back through the same port.

The interrupt line is a sticky flag. It is not an OR of masked status bits. Particular writes raise it: a descriptor B write with bit 29 set, or any write to the software-set offset. Other writes drop it: a control write with bit 16 set, a status write with bit 16 or bit 29 set, or any write to the software-clear offset. All other traffic leaves the line where it was.

Accesses are always full 32-bit words. Read data is registered and appears on the port one clock after the read strobe.

Top module: `hostirq_regs`

## Requirements
- R1: While reset is active, and after it, all five registers, the interrupt output and the read data are zero.
- R2: Writes at offset 0x028 (descriptor A) and 0x02C (descriptor B) store the full word, and a read of either offset returns it. Read data is presented on the clock edge that samples the read strobe and holds until the next read; before that edge the previous read value is still shown.
- R3: A descriptor B write whose data bit 29 is 1 sets the interrupt output at the next clock edge. With bit 29 at 0, the write leaves the interrupt unchanged.
- R4: A write at offset 0x04C (control) stores the word. If data bit 16 is 1, the interrupt output is cleared at the next edge.
- R5: A read of the control offset returns the stored control word with bit 17 forced to 1.
- R6: A write at offset 0x050 (status) stores the word. If data bit 16 or bit 29 is 1, the interrupt output is cleared at the next edge; otherwise it is unchanged.
- R7: A write at offset 0x1F0 ORs the data into the software interrupt word and always sets the interrupt output, even when the data is zero.
- R8: A write at offset 0x1F4 clears the software interrupt bits that are 1 in the data and always clears the interrupt output, even when the data is zero.
- R9: A read of either 0x1F0 or 0x1F4 returns the current software interrupt word.
- R10: Any other offset is unmapped, including offsets whose two low bits are not zero. A read there returns zero. A write there changes no register and does not affect the interrupt.
- R11: Reads, and writes that meet none of the set or clear conditions, leave the interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte offset of the access |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Registered read data |
| irqOut | output | 1 | Level-sensitive interrupt flag |

## Verification
The bench looks for side effects that are missed or leak into the wrong case:
- A zero-data write to either software offset must still move the interrupt. A design that gates the effect on nonzero data would leave the line stuck.
- Status writes are tried with only bit 16 set and with only bit 29 set. A design that tests one of the two bits would keep the line high on the other.
- A descriptor B write without bit 29 is checked to leave the line low. Writes to unmapped and misaligned offsets carry the raising bit pattern; an incomplete decode would store that data or raise the line.
- The control read-back is checked both with bit 17 forced and with the stored bits merged. The one-cycle read latency is probed before and after the sampling edge. A design that set the forced bit into storage, or that returned data combinationally, would show the wrong value.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;

  // Register offsets (byte addresses, word aligned)
  localparam logic [11:0] OFF_DESCA = 12'h028;
  localparam logic [11:0] OFF_DESCB = 12'h02C;
  localparam logic [11:0] OFF_CTRL  = 12'h04C;
  localparam logic [11:0] OFF_STAT  = 12'h050;
  localparam logic [11:0] OFF_SWSET = 12'h1F0;
  localparam logic [11:0] OFF_SWCLR = 12'h1F4;

  // Bit positions with side effects
  localparam int BIT_RAISE = 29;
  localparam int BIT_DROP  = 16;
  localparam int BIT_READY = 17;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DESCA,
    SEL_DESCB,
    SEL_CTRL,
    SEL_STAT,
    SEL_SWIRQ
  } rdSel_e;

  typedef struct packed {
    logic   wrDescA;
    logic   wrDescB;
    logic   wrCtrl;
    logic   wrStat;
    logic   wrSwSet;
    logic   wrSwClr;
    logic   irqSet;
    logic   irqClr;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
  import hostirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dataRaise,
  input  logic              dataDrop,
  output strobe_t           strobes
);

  logic hitDescA, hitDescB, hitCtrl, hitStat, hitSwSet, hitSwClr;

  always_comb begin
    hitDescA = (busAddr == ADDR_W'(OFF_DESCA));
    hitDescB = (busAddr == ADDR_W'(OFF_DESCB));
    hitCtrl  = (busAddr == ADDR_W'(OFF_CTRL));
    hitStat  = (busAddr == ADDR_W'(OFF_STAT));
    hitSwSet = (busAddr == ADDR_W'(OFF_SWSET));
    hitSwClr = (busAddr == ADDR_W'(OFF_SWCLR));
  end

  always_comb begin
    strobes = '0;
    strobes.wrDescA = busWr && hitDescA;
    strobes.wrDescB = busWr && hitDescB;
    strobes.wrCtrl  = busWr && hitCtrl;
    strobes.wrStat  = busWr && hitStat;
    strobes.wrSwSet = busWr && hitSwSet;
    strobes.wrSwClr = busWr && hitSwClr;

    // Interrupt side effects of writes
    strobes.irqSet = (busWr && hitDescB && dataRaise) || (busWr && hitSwSet);
    strobes.irqClr = (busWr && hitCtrl && dataDrop)
                   || (busWr && hitStat && (dataDrop || dataRaise))
                   || (busWr && hitSwClr);

    strobes.rdEn = busRd;
    if (hitDescA) begin
      strobes.rdSel = SEL_DESCA;
    end else if (hitDescB) begin
      strobes.rdSel = SEL_DESCB;
    end else if (hitCtrl) begin
      strobes.rdSel = SEL_CTRL;
    end else if (hitStat) begin
      strobes.rdSel = SEL_STAT;
    end else if (hitSwSet || hitSwClr) begin
      strobes.rdSel = SEL_SWIRQ;
    end else begin
      strobes.rdSel = SEL_NONE;
    end
  end

endmodule

// File: rtl/hostirq_dpath.sv
module hostirq_dpath
  import hostirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqFlag
);

  localparam logic [DATA_W-1:0] READY_MASK = DATA_W'(1) << BIT_READY;

  logic [DATA_W-1:0] descAReg, descBReg, ctrlReg, statReg, swIrqReg;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAReg <= '0;
      descBReg <= '0;
      ctrlReg  <= '0;
      statReg  <= '0;
      swIrqReg <= '0;
    end else begin
      if (strobes.wrDescA) descAReg <= wrData;
      if (strobes.wrDescB) descBReg <= wrData;
      if (strobes.wrCtrl)  ctrlReg  <= wrData;
      if (strobes.wrStat)  statReg  <= wrData;
      if (strobes.wrSwSet) swIrqReg <= swIrqReg | wrData;
      else if (strobes.wrSwClr) swIrqReg <= swIrqReg & ~wrData;
    end
  end

  // Sticky interrupt flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (strobes.irqSet) begin
      irqFlag <= 1'b1;
    end else if (strobes.irqClr) begin
      irqFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_DESCA: rdNext = descAReg;
      SEL_DESCB: rdNext = descBReg;
      SEL_CTRL:  rdNext = ctrlReg | READY_MASK;
      SEL_STAT:  rdNext = statReg;
      SEL_SWIRQ: rdNext = swIrqReg;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdEn) begin
      rdData <= rdNext;
    end
  end

endmodule

// File: rtl/hostirq_regs.sv
module hostirq_regs
  import hostirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  strobe_t strobes;

  hostirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .dataRaise(busWdata[BIT_RAISE]),
    .dataDrop (busWdata[BIT_DROP]),
    .strobes  (strobes)
  );

  hostirq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (busWdata),
    .rdData (busRdata),
    .irqFlag(irqOut)
  );

endmodule

// File: rtl/hostirq_checker.sv
module hostirq_checker
  import hostirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic              wdRaise,
  input logic              wdDrop,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut
);

  logic atDescB, atCtrl, atStat, atSet, atClr, atMapped;
  assign atDescB  = busAddr == ADDR_W'(OFF_DESCB);
  assign atCtrl   = busAddr == ADDR_W'(OFF_CTRL);
  assign atStat   = busAddr == ADDR_W'(OFF_STAT);
  assign atSet    = busAddr == ADDR_W'(OFF_SWSET);
  assign atClr    = busAddr == ADDR_W'(OFF_SWCLR);
  assign atMapped = atDescB || atCtrl || atStat || atSet || atClr
                 || busAddr == ADDR_W'(OFF_DESCA);

  p_descb_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWr && atDescB && wdRaise |=> irqOut);

  p_ctrl_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWr && atCtrl && wdDrop |=> !irqOut);

  p_ctrl_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRd && atCtrl |=> busRdata[BIT_READY]);

  p_stat_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && atStat && (wdDrop || wdRaise) |=> !irqOut);

  p_sw_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWr && atSet |=> irqOut);

  p_sw_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWr && atClr |=> !irqOut);

  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !atMapped |=> busRdata == '0);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(irqOut));

endmodule

bind hostirq_regs hostirq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .wdRaise (busWdata[29]),
  .wdDrop  (busWdata[16]),
  .busRdata(busRdata),
  .irqOut  (irqOut)
);

// File: tb/hostirq_regs_bench.sv
module hostirq_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 30;

  // vector: {op[1:0], addr[11:0], data[31:0], expRd[31:0], expIrq, req[3:0]}
  // op: 0 idle, 1 write, 2 read
  localparam logic [82:0] VEC [NVEC] = '{
    {2'd2, 12'h028, 32'h0,         32'h0,         1'b0, 4'd1},  // R1
    {2'd2, 12'h04C, 32'h0,         32'h0002_0000, 1'b0, 4'd5},  // R5
    {2'd1, 12'h028, 32'h1234_5678, 32'h0,         1'b0, 4'd2},  // R2
    {2'd2, 12'h028, 32'h0,         32'h1234_5678, 1'b0, 4'd2},  // R2
    {2'd1, 12'h02C, 32'h0000_00FF, 32'h0,         1'b0, 4'd3},  // R3
    {2'd1, 12'h02C, 32'h2000_0001, 32'h0,         1'b1, 4'd3},  // R3
    {2'd2, 12'h02C, 32'h0,         32'h2000_0001, 1'b1, 4'd2},  // R2
    {2'd1, 12'h04C, 32'h0000_0005, 32'h0,         1'b1, 4'd11}, // R11
    {2'd2, 12'h04C, 32'h0,         32'h0002_0005, 1'b1, 4'd5},  // R5
    {2'd1, 12'h04C, 32'h0001_0000, 32'h0,         1'b0, 4'd4},  // R4
    {2'd2, 12'h04C, 32'h0,         32'h0003_0000, 1'b0, 4'd5},  // R5
    {2'd1, 12'h1F0, 32'h0000_00A0, 32'h0,         1'b1, 4'd7},  // R7
    {2'd1, 12'h1F0, 32'h0000_0005, 32'h0,         1'b1, 4'd7},  // R7
    {2'd2, 12'h1F0, 32'h0,         32'h0000_00A5, 1'b1, 4'd9},  // R9
    {2'd1, 12'h050, 32'h0000_0003, 32'h0,         1'b1, 4'd6},  // R6
    {2'd2, 12'h050, 32'h0,         32'h0000_0003, 1'b1, 4'd6},  // R6
    {2'd1, 12'h050, 32'h2000_0000, 32'h0,         1'b0, 4'd6},  // R6
    {2'd1, 12'h1F0, 32'h0,         32'h0,         1'b1, 4'd7},  // R7
    {2'd1, 12'h050, 32'h0001_0000, 32'h0,         1'b0, 4'd6},  // R6
    {2'd1, 12'h1F0, 32'h0,         32'h0,         1'b1, 4'd7},  // R7
    {2'd1, 12'h1F4, 32'h0000_0021, 32'h0,         1'b0, 4'd8},  // R8
    {2'd2, 12'h1F4, 32'h0,         32'h0000_0084, 1'b0, 4'd9},  // R9
    {2'd1, 12'h02C, 32'h2000_0000, 32'h0,         1'b1, 4'd3},  // R3
    {2'd1, 12'h100, 32'hFFFF_FFFF, 32'h0,         1'b1, 4'd10}, // R10
    {2'd2, 12'h100, 32'h0,         32'h0,         1'b1, 4'd10}, // R10
    {2'd1, 12'h1F4, 32'h0,         32'h0,         1'b0, 4'd8},  // R8
    {2'd1, 12'h02A, 32'h2000_0000, 32'h0,         1'b0, 4'd10}, // R10
    {2'd2, 12'h02C, 32'h0,         32'h2000_0000, 1'b0, 4'd10}, // R10
    {2'd2, 12'h050, 32'h0,         32'h0001_0000, 1'b0, 4'd11}, // R11
    {2'd2, 12'h028, 32'h0,         32'h1234_5678, 1'b0, 4'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  hostirq_regs u_hostirq_regs (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access at a falling edge; returns at the next falling edge
  task automatic access(input logic [1:0] op, input logic [11:0] addr, input logic [31:0] data);
    busWr    = (op == 2'd1);
    busRd    = (op == 2'd2);
    busAddr  = addr;
    busWdata = data;
    @(negedge clk);
    busWr = 1'b0;
    busRd = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      nErrors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check("R1 irq in reset", {31'b0, irqOut}, 32'h0);
    check("R1 rdata in reset", busRdata, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [82:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec %0d", v[3:0], i);
      access(v[82:81], v[80:69], v[68:37]);
      if (v[82:81] == 2'd2) check({tag, " rdata"}, busRdata, v[36:5]);
      check({tag, " irq"}, {31'b0, irqOut}, {31'b0, v[4]});
    end

    // R2: read latency, old value visible until the sampling edge
    access(2'd1, 12'h028, 32'hCAFE_F00D);
    access(2'd2, 12'h02C, 32'h0);
    check("R2 prior read", busRdata, 32'h2000_0000);
    busRd   = 1'b1;
    busAddr = 12'h028;
    #(CLK_PERIOD/4);
    check("R2 before edge", busRdata, 32'h2000_0000);
    @(negedge clk);
    busRd = 1'b0;
    check("R2 after edge", busRdata, 32'hCAFE_F00D);
    @(negedge clk);
    check("R2 hold", busRdata, 32'hCAFE_F00D);

    // R11: a read does not disturb a raised interrupt
    access(2'd1, 12'h1F0, 32'h0000_0010);
    access(2'd2, 12'h1F4, 32'h0);
    check("R11 irq after read", {31'b0, irqOut}, 32'h1);
    check("R9 swirq via clear offset", busRdata, 32'h0000_0094);

    // R1: reset mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    access(2'd2, 12'h028, 32'h0);
    check("R1 descA after reset", busRdata, 32'h0);
    access(2'd2, 12'h1F0, 32'h0);
    check("R1 swirq after reset", busRdata, 32'h0);
    access(2'd2, 12'h04C, 32'h0);
    check("R1 ctrl after reset", busRdata, 32'h0002_0000);
    access(2'd2, 12'h050, 32'h0);
    check("R1 stat after reset", busRdata, 32'h0);
    access(2'd2, 12'h02C, 32'h0);
    check("R1 descB after reset", busRdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule